// File: doc/BRIEF.md
# Configurable Pad Interface Cell

This block sits between core logic and one bidirectional package pin. A set of static configuration inputs decides whether the pin is unused, input only, output only or bidirectional. On the receive side the pad value reaches the core either combinationally or through a capture element. That element is an edge-triggered flop or a level-sensitive latch, and its clock can be inverted. An optional extra retiming stage can follow it.

On the transmit side the core value can be inverted. It then reaches the pin driver either directly or through an output flop, whose clock can also be inverted. The driver is released to high impedance by a per-pin control or by a chip-wide tri-state line. That line is held high while the chip is being configured. An unused pin can be tied to a selectable pull level. Reset is asserted asynchronously and released through a synchroniser.

Top module: `pad_io_cell`

## Requirements
- R1: While reset is asserted every storage element is cleared, so with the registered receive path selected `core_in` reads 0. Mode encoding on `cfg_mode`: 2'b00 unused, 2'b01 input only, 2'b10 output only, 2'b11 bidirectional.
- R2: While `glob_tri` is 1 the cell never drives the pin, in any mode.
- R3: In bidirectional mode the cell drives the pin only when `core_t` is 0 and `glob_tri` is 0; `core_t` = 1 releases the pin and the pin value is then visible on `core_in`.
- R4: In output-only mode the cell drives the pin whenever `glob_tri` is 0, whatever `core_t` is, and `core_in` reads 0.
- R5: In input-only mode the cell never drives the pin. With `cfg_in_reg` = 0, `core_in` follows the pin combinationally.
- R6: With `cfg_in_reg` = 1 and `cfg_in_latch` = 0, `core_in` takes the pin value at the rising edge of the receive clock. That clock is `clk` when `cfg_in_clk_inv` = 0, and the falling edge of `clk` when it is 1.
- R7: With `cfg_in_reg` = 1 and `cfg_in_latch` = 1, `core_in` is transparent to the pin while the receive clock is high and holds while it is low.
- R8: With `cfg_in_dly` = 1 the registered receive path gains exactly one extra receive-clock cycle of latency.
- R9: The value driven on the pin is `core_out` XOR `cfg_out_inv`.
- R10: With `cfg_out_reg` = 1 the driven value changes only at the rising edge of the transmit clock. That clock is `clk` when `cfg_out_clk_inv` = 0, and the falling edge of `clk` when it is 1.
- R11: In unused mode `cfg_pull` = 2'b01 ties the pin low, 2'b10 ties it high, and 2'b00 or 2'b11 leaves it floating; `core_in` reads 0.
- R12: Assertion of `rst_n` clears the storage at once. Release takes effect after 2 rising edges of `clk`, so the first capture happens at the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Pin use: unused, input, output, bidirectional |
| cfg_pull | input | 2 | Tie level for an unused pin |
| cfg_in_reg | input | 1 | 1 selects the registered receive path |
| cfg_in_latch | input | 1 | 1 makes the capture element a level latch |
| cfg_in_clk_inv | input | 1 | Inverts the receive clock |
| cfg_in_dly | input | 1 | Adds the retiming stage on the receive path |
| cfg_out_inv | input | 1 | Inverts the transmit data |
| cfg_out_reg | input | 1 | 1 selects the registered transmit path |
| cfg_out_clk_inv | input | 1 | Inverts the transmit clock |
| glob_tri | input | 1 | Chip-wide tri-state, high during configuration |
| core_t | input | 1 | Per-pin tri-state control, 1 releases the pin |
| core_out | input | 1 | Data from core logic to the pin |
| core_in | output | 1 | Data from the pin to core logic |
| pad | inout | 1 | Package pin |

## Verification
The bench holds the pin on a net that floats high. Release is therefore seen as a 1 while the cell would be driving 0, so a cell that ignored `glob_tri` or `core_t`, or drove in input mode, would read 0 instead. Inverted-clock paths are sampled between the falling and the next rising edge: a design that kept the plain clock would still show the old value there. Latch mode is probed by changing the pin while the clock is low, where a flop-like capture or an always-open latch would show the wrong value. The delay stage and the reset synchroniser are checked cycle by cycle, so one stage too many or too few moves the first changed sample.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  typedef enum logic [1:0] {
    PM_UNUSED = 2'b00,
    PM_IN     = 2'b01,
    PM_OUT    = 2'b10,
    PM_BIDIR  = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PL_NONE = 2'b00,
    PL_DOWN = 2'b01,
    PL_UP   = 2'b10,
    PL_RSVD = 2'b11
  } pull_sel_e;
endpackage

// File: rtl/pad_rst_sync.sv
module pad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sh_q;
  logic [MSB:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[MSB-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[MSB];
endmodule

// File: rtl/pad_rx_path.sv
module pad_rx_path (
  input  logic rclk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic use_reg,
  input  logic use_latch,
  input  logic use_dly,
  input  logic pin_val,
  output logic rx_out
);
  logic flop_q;
  logic latch_q;
  logic cap_val;
  logic dly_q;
  logic reg_val;

  // edge capture
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) flop_q <= 1'b0;
    else        flop_q <= pin_val;
  end

  // level capture, open while the receive clock is high
  always_latch begin
    if (!rst_n)    latch_q = 1'b0;
    else if (rclk) latch_q = pin_val;
  end

  always_comb cap_val = use_latch ? latch_q : flop_q;

  // retiming stage on the same receive clock
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) dly_q <= 1'b0;
    else        dly_q <= cap_val;
  end

  always_comb begin
    reg_val = use_dly ? dly_q : cap_val;
    rx_out  = 1'b0;
    if (rd_en) rx_out = use_reg ? reg_val : pin_val;
  end
endmodule

// File: rtl/pad_tx_path.sv
module pad_tx_path (
  input  logic tclk,
  input  logic rst_n,
  input  logic core_val,
  input  logic inv,
  input  logic use_reg,
  output logic tx_val
);
  logic d_val;
  logic out_q;

  always_comb d_val = core_val ^ inv;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= d_val;
  end

  always_comb tx_val = use_reg ? out_q : d_val;
endmodule

// File: rtl/pad_io_cell.sv
module pad_io_cell
  import pad_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_pull,
  input  logic       cfg_in_reg,
  input  logic       cfg_in_latch,
  input  logic       cfg_in_clk_inv,
  input  logic       cfg_in_dly,
  input  logic       cfg_out_inv,
  input  logic       cfg_out_reg,
  input  logic       cfg_out_clk_inv,
  input  logic       glob_tri,
  input  logic       core_t,
  input  logic       core_out,
  output logic       core_in,
  inout  wire        pad
);
  pin_mode_e mode;
  pull_sel_e pull;
  logic      rst_s;
  logic      rclk;
  logic      tclk;
  logic      pad_rd;
  logic      rd_en;
  logic      drv_en;
  logic      drv_val;
  logic      tie_en;
  logic      tie_val;

  always_comb begin
    mode = pin_mode_e'(cfg_mode);
    pull = pull_sel_e'(cfg_pull);
  end

  pad_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  assign rclk   = clk ^ cfg_in_clk_inv;
  assign tclk   = clk ^ cfg_out_clk_inv;
  assign pad_rd = pad;

  always_comb begin
    rd_en   = (mode == PM_IN) || (mode == PM_BIDIR);
    drv_en  = 1'b0;
    if (!glob_tri) begin
      if (mode == PM_OUT)                drv_en = 1'b1;
      else if (mode == PM_BIDIR && !core_t) drv_en = 1'b1;
    end
    tie_en  = (mode == PM_UNUSED) && (pull == PL_DOWN || pull == PL_UP);
    tie_val = (pull == PL_UP);
  end

  pad_rx_path u_rx (
    .rclk      (rclk),
    .rst_n     (rst_s),
    .rd_en     (rd_en),
    .use_reg   (cfg_in_reg),
    .use_latch (cfg_in_latch),
    .use_dly   (cfg_in_dly),
    .pin_val   (pad_rd),
    .rx_out    (core_in)
  );

  pad_tx_path u_tx (
    .tclk     (tclk),
    .rst_n    (rst_s),
    .core_val (core_out),
    .inv      (cfg_out_inv),
    .use_reg  (cfg_out_reg),
    .tx_val   (drv_val)
  );

  assign pad = drv_en ? drv_val : (tie_en ? tie_val : 1'bz);
endmodule

// File: rtl/pad_io_cell_chk.sv
module pad_io_cell_chk (
  input logic       clk,
  input logic       rst_s,
  input logic [1:0] cfg_mode,
  input logic [1:0] cfg_pull,
  input logic       cfg_in_reg,
  input logic       cfg_in_latch,
  input logic       cfg_in_clk_inv,
  input logic       cfg_in_dly,
  input logic       cfg_out_inv,
  input logic       cfg_out_reg,
  input logic       cfg_out_clk_inv,
  input logic       glob_tri,
  input logic       core_out,
  input logic       core_in,
  input logic       pad_rd,
  input logic       drv_en,
  input logic       drv_val
);
  logic [1:0] warm;
  logic       rx_plain;
  logic       tx_plain;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign rx_plain = cfg_in_reg && !cfg_in_latch && !cfg_in_clk_inv && !cfg_in_dly
                    && (cfg_mode == 2'b01 || cfg_mode == 2'b11);
  assign tx_plain = cfg_out_reg && !cfg_out_clk_inv;

  a_r2_global_release: assert property (@(posedge clk) disable iff (!rst_s)
    glob_tri |-> !drv_en);

  a_r4_out_drives: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_mode == 2'b10 && !glob_tri) |-> (drv_en && core_in == 1'b0));

  a_r5_in_silent: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_mode == 2'b01) |-> !drv_en);

  a_r6_rx_capture: assert property (@(posedge clk) disable iff (!rst_s)
    (warm >= 2'd2 && rx_plain && $past(rx_plain)) |-> (core_in == $past(pad_rd)));

  a_r10_tx_capture: assert property (@(posedge clk) disable iff (!rst_s)
    (warm >= 2'd2 && tx_plain && $past(tx_plain) && $stable(cfg_out_inv))
      |-> (drv_val == $past(core_out ^ cfg_out_inv)));

  a_r11_tie_low: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_mode == 2'b00 && cfg_pull == 2'b01) |-> (pad_rd == 1'b0 && core_in == 1'b0));
endmodule

bind pad_io_cell pad_io_cell_chk u_chk (
  .clk             (clk),
  .rst_s           (rst_s),
  .cfg_mode        (cfg_mode),
  .cfg_pull        (cfg_pull),
  .cfg_in_reg      (cfg_in_reg),
  .cfg_in_latch    (cfg_in_latch),
  .cfg_in_clk_inv  (cfg_in_clk_inv),
  .cfg_in_dly      (cfg_in_dly),
  .cfg_out_inv     (cfg_out_inv),
  .cfg_out_reg     (cfg_out_reg),
  .cfg_out_clk_inv (cfg_out_clk_inv),
  .glob_tri        (glob_tri),
  .core_out        (core_out),
  .core_in         (core_in),
  .pad_rd          (pad_rd),
  .drv_en          (drv_en),
  .drv_val         (drv_val)
);

// File: tb/sim_pad_io_cell.sv
`timescale 1ns/1ps
module sim_pad_io_cell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [1:0] cfg_pull;
  logic       cfg_in_reg, cfg_in_latch, cfg_in_clk_inv, cfg_in_dly;
  logic       cfg_out_inv, cfg_out_reg, cfg_out_clk_inv;
  logic       glob_tri, core_t, core_out;
  logic       core_in;
  logic       tb_en, tb_val;
  tri1        pad_w;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign pad_w = tb_en ? tb_val : 1'bz;

  pad_io_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pull(cfg_pull),
    .cfg_in_reg(cfg_in_reg), .cfg_in_latch(cfg_in_latch),
    .cfg_in_clk_inv(cfg_in_clk_inv), .cfg_in_dly(cfg_in_dly),
    .cfg_out_inv(cfg_out_inv), .cfg_out_reg(cfg_out_reg),
    .cfg_out_clk_inv(cfg_out_clk_inv), .glob_tri(glob_tri),
    .core_t(core_t), .core_out(core_out), .core_in(core_in), .pad(pad_w)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic defaults();
    cfg_pull = 2'b00; cfg_in_reg = 0; cfg_in_latch = 0; cfg_in_clk_inv = 0;
    cfg_in_dly = 0; cfg_out_inv = 0; cfg_out_reg = 0; cfg_out_clk_inv = 0;
    core_t = 0; core_out = 0; tb_en = 0; tb_val = 0;
  endtask

  task automatic t_reset();
    defaults();
    cfg_mode = 2'b01; cfg_in_reg = 1; glob_tri = 1; tb_en = 1; tb_val = 1;
    rst_n = 0;
    step(); step();
    chk(core_in, 1'b0, "R1", "registered input held in reset");
    chk(pad_w, 1'b1, "R2", "pin released during configuration");
    rst_n = 1;
    step();
    chk(core_in, 1'b0, "R12", "no capture one edge after release");
    step();
    chk(core_in, 1'b0, "R12", "no capture two edges after release");
    step();
    chk(core_in, 1'b1, "R12", "capture at third edge after release");
    rst_n = 0; #1;
    chk(core_in, 1'b0, "R12", "asynchronous clear");
    #1; rst_n = 1;
    step(); step(); step();
    glob_tri = 0;
    tb_en = 0;
  endtask

  task automatic t_global();
    defaults();
    cfg_mode = 2'b11; core_t = 0; core_out = 0; glob_tri = 1;
    step();
    chk(pad_w, 1'b1, "R2", "global tri-state overrides drive");
    glob_tri = 0; #1;
    chk(pad_w, 1'b0, "R3", "bidir drives when both controls low");
    glob_tri = 0;
  endtask

  task automatic t_bidir();
    defaults();
    cfg_mode = 2'b11; core_t = 1; core_out = 0; glob_tri = 0;
    step();
    chk(pad_w, 1'b1, "R3", "per-pin control releases pin");
    tb_en = 1; tb_val = 0; #1;
    chk(core_in, 1'b0, "R3", "released pin read back 0");
    tb_val = 1; #1;
    chk(core_in, 1'b1, "R3", "released pin read back 1");
    tb_en = 0;
  endtask

  task automatic t_out_only();
    defaults();
    cfg_mode = 2'b10; core_t = 1; core_out = 0; glob_tri = 0;
    step();
    chk(pad_w, 1'b0, "R4", "output mode ignores per-pin control");
    core_out = 1; #1;
    chk(pad_w, 1'b1, "R4", "output mode drives 1");
    chk(core_in, 1'b0, "R4", "output mode input reads 0");
  endtask

  task automatic t_in_only();
    defaults();
    cfg_mode = 2'b01; core_out = 0; glob_tri = 0;
    step();
    chk(pad_w, 1'b1, "R5", "input mode never drives");
    tb_en = 1; tb_val = 0; #1;
    chk(core_in, 1'b0, "R5", "direct path 0");
    tb_val = 1; #1;
    chk(core_in, 1'b1, "R5", "direct path 1");
    tb_en = 0;
  endtask

  task automatic t_in_edge();
    defaults();
    cfg_mode = 2'b01; cfg_in_reg = 1; tb_en = 1; tb_val = 0;
    step(); step();
    tb_val = 1; #1;
    chk(core_in, 1'b0, "R6", "no change before rising edge");
    step();
    chk(core_in, 1'b1, "R6", "captured at rising edge");
    cfg_in_clk_inv = 1;
    step(); step();
    tb_val = 0; #2;
    chk(core_in, 1'b1, "R6", "inverted clock holds while clk high");
    #3;
    chk(core_in, 1'b0, "R6", "inverted clock captures at falling edge");
    tb_en = 0;
  endtask

  task automatic t_latch();
    defaults();
    cfg_mode = 2'b01; cfg_in_reg = 1; cfg_in_latch = 1; tb_en = 1; tb_val = 0;
    step();
    tb_val = 1; #1;
    chk(core_in, 1'b1, "R7", "transparent while clock high");
    #4;
    tb_val = 0; #1;
    chk(core_in, 1'b1, "R7", "holds while clock low");
    step();
    chk(core_in, 1'b0, "R7", "reopens at clock high");
    tb_en = 0;
  endtask

  task automatic t_delay();
    defaults();
    cfg_mode = 2'b01; cfg_in_reg = 1; cfg_in_dly = 1; tb_en = 1; tb_val = 0;
    step(); step(); step();
    tb_val = 1;
    step();
    chk(core_in, 1'b0, "R8", "delay stage hides first edge");
    step();
    chk(core_in, 1'b1, "R8", "value after second edge");
    tb_en = 0;
  endtask

  task automatic t_out_inv();
    defaults();
    cfg_mode = 2'b10; cfg_out_inv = 1; core_out = 1; glob_tri = 0;
    step();
    chk(pad_w, 1'b0, "R9", "inverted 1 drives 0");
    core_out = 0; #1;
    chk(pad_w, 1'b1, "R9", "inverted 0 drives 1");
  endtask

  task automatic t_out_reg();
    defaults();
    cfg_mode = 2'b10; cfg_out_reg = 1; core_out = 0; glob_tri = 0;
    step(); step();
    core_out = 1; #1;
    chk(pad_w, 1'b0, "R10", "held before rising edge");
    step();
    chk(pad_w, 1'b1, "R10", "updated at rising edge");
    cfg_out_clk_inv = 1;
    step(); step();
    core_out = 0; #2;
    chk(pad_w, 1'b1, "R10", "inverted clock holds while clk high");
    #3;
    chk(pad_w, 1'b0, "R10", "inverted clock updates at falling edge");
  endtask

  task automatic t_pull();
    defaults();
    cfg_mode = 2'b00; cfg_pull = 2'b01; glob_tri = 0;
    step();
    chk(pad_w, 1'b0, "R11", "unused pin tied low");
    chk(core_in, 1'b0, "R11", "unused pin input reads 0");
    cfg_pull = 2'b10; #1;
    chk(pad_w, 1'b1, "R11", "unused pin tied high");
    cfg_pull = 2'b11; #1;
    chk(pad_w, 1'b1, "R11", "reserved pull floats");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    cfg_mode = 2'b01; glob_tri = 1; defaults(); rst_n = 0;
    t_reset();
    t_global();
    t_bidir();
    t_out_only();
    t_in_only();
    t_in_edge();
    t_latch();
    t_delay();
    t_out_inv();
    t_out_reg();
    t_pull();
    summary();
    $finish;
  end
endmodule